// File: doc/BRIEF.md
# Line-Quadding VGA Scan-Out Engine

This block turns a small 160 by 120 framebuffer into a full 640 by 480 VGA picture. It runs its own horizontal and vertical counters from a 25 MHz pixel clock, so sync timing never depends on whatever host fills the framebuffer. It fetches pixels through a read port with one cycle of latency. Each stored pixel is shown on four neighbouring output pixels and each stored row on four consecutive output lines, so the host only ever provides 120 rows.

The output carries active-low horizontal and vertical syncs, a blanking flag, 6-bit RGB with two bits per channel, and a one-clock pulse on the first visible pixel of every frame. An optional dither shows a shade between two neighbouring levels by raising alternate output pixels one step in a checkerboard. A second option reverses the checkerboard on every frame. Both options are inputs that the system ties low when it does not use them.

All timing figures are parameters, and the defaults give standard 640x480 at 60 Hz. The scale factors and the source size are derived from the parameters.

Top module: `vqScanOut`

## Requirements
- R1: While `rstN` is low, `blankOut` is 1, `hSyncN` and `vSyncN` are 1, `rgbOut` is 0 and `frameStart` is 0.
- R2: Take the output pixel after `frameStart` as column 0. Each line lasts H_VISIBLE+H_FRONT+H_SYNC+H_BACK clocks (800 by default). `hSyncN` is low exactly on columns H_VISIBLE+H_FRONT up to H_VISIBLE+H_FRONT+H_SYNC-1 (656 to 751 by default).
- R3: Each frame lasts V_VISIBLE+V_FRONT+V_SYNC+V_BACK lines (525 by default). `vSyncN` is low for the whole of lines V_VISIBLE+V_FRONT up to V_VISIBLE+V_FRONT+V_SYNC-1 (490 and 491 by default).
- R4: `blankOut` is 0 exactly when column < H_VISIBLE and line < V_VISIBLE. `rgbOut` is 0 whenever `blankOut` is 1.
- R5: `frameStart` is 1 for exactly one clock, at column 0 of line 0. This repeats every frame, whatever the data and option inputs do.
- R6: The visible pixel at (column x, line y) shows the stored word at address (y>>2)*SRC_W + (x>>2), where SRC_W = H_VISIBLE>>2 (160 by default). The read port returns the word one clock after it samples `fbRdAddr` while `fbRdEn` is 1, and `fbRdEn` is asserted only with addresses below SRC_W*SRC_H.
- R7: With `ditherEn` at 0, a visible pixel shows the stored word unchanged. The encoding is blue in bits [1:0], green in bits [3:2] and red in bits [5:4].
- R8: With `ditherEn` at 1, a visible pixel whose parity x[0]^y[0]^phase is 1 has each channel raised by one. A channel already at 3 stays at 3. Pixels with parity 0 show the stored word.
- R9: The phase is 0 in the first frame after reset. At each later frame start the phase becomes the inverse of the previous phase if `ditherFlipEn` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| ditherEn | input | 1 | Enables checkerboard dither |
| ditherFlipEn | input | 1 | Reverses the dither checkerboard every frame |
| fbRdEn | output | 1 | Framebuffer read strobe |
| fbRdAddr | output | ADDR_W (15) | Framebuffer word address |
| fbRdData | input | 6 | Framebuffer word, one clock after the address |
| rgbOut | output | 6 | Pixel colour {red, green, blue}, 2 bits each |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| blankOut | output | 1 | High outside the visible area |
| frameStart | output | 1 | One-clock pulse on the first visible pixel |

## Verification
Every frame the framebuffer returns a pseudo-random word computed from the address and a per-frame seed. A wrong source row, a wrong column scale or a misaligned read therefore shows up as a colour mismatch, not as a plausible image. A frame where every word is all-ones, with dither on, tells a saturating bump apart from one that wraps to zero. Consecutive frames with the flip option on, then a frame with it off, tell apart a phase that toggles, one that sticks, and one that fails to clear. Frames with dither off confirm that the data passes through unchanged.

// File: rtl/vqPkg.sv
package vqPkg;

  // Per-pixel control strobes handed from the timing control to the datapath
  typedef struct packed {
    logic active;
    logic hSyncN;
    logic vSyncN;
    logic frameStart;
    logic ditherOdd;
  } scanStrobe_t;

  localparam scanStrobe_t STROBE_IDLE = '{
    active:     1'b0,
    hSyncN:     1'b1,
    vSyncN:     1'b1,
    frameStart: 1'b0,
    ditherOdd:  1'b0
  };

endpackage

// File: rtl/vqTiming.sv
module vqTiming
  import vqPkg::*;
#(
  parameter int H_VISIBLE    = 640,
  parameter int H_FRONT      = 16,
  parameter int H_SYNC       = 96,
  parameter int H_BACK       = 48,
  parameter int V_VISIBLE    = 480,
  parameter int V_FRONT      = 10,
  parameter int V_SYNC       = 2,
  parameter int V_BACK       = 33,
  parameter int H_SCALE_LOG2 = 2,
  parameter int V_SCALE_LOG2 = 2,
  parameter int ADDR_W       = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flipEn,
  output logic              fbRdEn,
  output logic [ADDR_W-1:0] fbRdAddr,
  output scanStrobe_t       stb
);

  localparam int H_TOTAL = H_VISIBLE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_VISIBLE + V_FRONT + V_SYNC + V_BACK;
  localparam int H_CNT_W = $clog2(H_TOTAL);
  localparam int V_CNT_W = $clog2(V_TOTAL);
  localparam int SRC_W   = H_VISIBLE >> H_SCALE_LOG2;

  localparam logic [H_CNT_W-1:0] H_VIS_C   = H_CNT_W'(H_VISIBLE);
  localparam logic [H_CNT_W-1:0] H_SBEG_C  = H_CNT_W'(H_VISIBLE + H_FRONT);
  localparam logic [H_CNT_W-1:0] H_SEND_C  = H_CNT_W'(H_VISIBLE + H_FRONT + H_SYNC);
  localparam logic [H_CNT_W-1:0] H_LAST_C  = H_CNT_W'(H_TOTAL - 1);
  localparam logic [V_CNT_W-1:0] V_VIS_C   = V_CNT_W'(V_VISIBLE);
  localparam logic [V_CNT_W-1:0] V_SBEG_C  = V_CNT_W'(V_VISIBLE + V_FRONT);
  localparam logic [V_CNT_W-1:0] V_SEND_C  = V_CNT_W'(V_VISIBLE + V_FRONT + V_SYNC);
  localparam logic [V_CNT_W-1:0] V_LAST_C  = V_CNT_W'(V_TOTAL - 1);
  localparam logic [ADDR_W-1:0]  SRC_W_C   = ADDR_W'(SRC_W);

  logic [H_CNT_W-1:0] hCnt;
  logic [V_CNT_W-1:0] vCnt;
  logic               phase;
  logic               lineEnd;
  logic               frameEnd;
  logic [ADDR_W-1:0]  rowIdx;
  logic [ADDR_W-1:0]  colIdx;
  logic [ADDR_W-1:0]  addrNow;
  scanStrobe_t        stbNow;

  assign lineEnd  = (hCnt == H_LAST_C);
  assign frameEnd = lineEnd && (vCnt == V_LAST_C);

  // Free-running raster counters; the phase flips on the last pixel of a frame
  // so that pixel (0,0) of the next frame already uses the new phase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt  <= '0;
      vCnt  <= '0;
      phase <= 1'b0;
    end else begin
      if (lineEnd) begin
        hCnt <= '0;
        if (vCnt == V_LAST_C) vCnt <= '0;
        else                  vCnt <= vCnt + V_CNT_W'(1);
      end else begin
        hCnt <= hCnt + H_CNT_W'(1);
      end
      if (frameEnd) phase <= flipEn ? ~phase : 1'b0;
    end
  end

  // Source coordinates: drop the replication bits of each counter
  assign rowIdx  = ADDR_W'(vCnt >> V_SCALE_LOG2);
  assign colIdx  = ADDR_W'(hCnt >> H_SCALE_LOG2);
  assign addrNow = rowIdx * SRC_W_C + colIdx;

  always_comb begin
    stbNow            = STROBE_IDLE;
    stbNow.active     = (hCnt < H_VIS_C) && (vCnt < V_VIS_C);
    stbNow.hSyncN     = !((hCnt >= H_SBEG_C) && (hCnt < H_SEND_C));
    stbNow.vSyncN     = !((vCnt >= V_SBEG_C) && (vCnt < V_SEND_C));
    stbNow.frameStart = (hCnt == '0) && (vCnt == '0);
    stbNow.ditherOdd  = hCnt[0] ^ vCnt[0] ^ phase;
  end

  // The read is issued here, ahead of the datapath stage that consumes it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fbRdEn   <= 1'b0;
      fbRdAddr <= '0;
      stb      <= STROBE_IDLE;
    end else begin
      fbRdEn   <= stbNow.active;
      fbRdAddr <= addrNow;
      stb      <= stbNow;
    end
  end

endmodule

// File: rtl/vqPixelPath.sv
module vqPixelPath
  import vqPkg::*;
#(
  parameter int COLOR_BITS = 2,
  parameter int CHANNELS   = 3,
  parameter int PIX_W      = COLOR_BITS * CHANNELS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ditherEn,
  input  scanStrobe_t      stbIn,
  input  logic [PIX_W-1:0] fbRdData,
  output logic [PIX_W-1:0] rgbOut,
  output logic             hSyncN,
  output logic             vSyncN,
  output logic             blankOut,
  output logic             frameStart
);

  localparam logic [COLOR_BITS-1:0] CH_MAX = '1;

  scanStrobe_t      stbData;
  logic [PIX_W-1:0] pixShaded;
  logic [PIX_W-1:0] pixNext;
  logic             bumpNow;

  // Align the strobes with the word the read port returns
  always_ff @(posedge clk) begin
    if (!rstN) stbData <= STROBE_IDLE;
    else       stbData <= stbIn;
  end

  assign bumpNow = ditherEn && stbData.ditherOdd;

  for (genvar c = 0; c < CHANNELS; c++) begin : gChan
    logic [COLOR_BITS-1:0] chIn;
    logic [COLOR_BITS-1:0] chUp;
    assign chIn = fbRdData[c*COLOR_BITS +: COLOR_BITS];
    assign chUp = (chIn == CH_MAX) ? chIn : chIn + COLOR_BITS'(1);
    assign pixShaded[c*COLOR_BITS +: COLOR_BITS] = bumpNow ? chUp : chIn;
  end

  assign pixNext = stbData.active ? pixShaded : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rgbOut     <= '0;
      hSyncN     <= 1'b1;
      vSyncN     <= 1'b1;
      blankOut   <= 1'b1;
      frameStart <= 1'b0;
    end else begin
      rgbOut     <= pixNext;
      hSyncN     <= stbData.hSyncN;
      vSyncN     <= stbData.vSyncN;
      blankOut   <= !stbData.active;
      frameStart <= stbData.frameStart;
    end
  end

endmodule

// File: rtl/vqScanOut.sv
module vqScanOut
  import vqPkg::*;
#(
  parameter int H_VISIBLE    = 640,
  parameter int H_FRONT      = 16,
  parameter int H_SYNC       = 96,
  parameter int H_BACK       = 48,
  parameter int V_VISIBLE    = 480,
  parameter int V_FRONT      = 10,
  parameter int V_SYNC       = 2,
  parameter int V_BACK       = 33,
  parameter int H_SCALE_LOG2 = 2,
  parameter int V_SCALE_LOG2 = 2,
  parameter int COLOR_BITS   = 2,
  localparam int PIX_W       = 3 * COLOR_BITS,
  localparam int SRC_CNT     = (H_VISIBLE >> H_SCALE_LOG2) * (V_VISIBLE >> V_SCALE_LOG2),
  localparam int ADDR_W      = $clog2(SRC_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ditherEn,
  input  logic              ditherFlipEn,
  output logic              fbRdEn,
  output logic [ADDR_W-1:0] fbRdAddr,
  input  logic [PIX_W-1:0]  fbRdData,
  output logic [PIX_W-1:0]  rgbOut,
  output logic              hSyncN,
  output logic              vSyncN,
  output logic              blankOut,
  output logic              frameStart
);

  scanStrobe_t stb;

  vqTiming #(
    .H_VISIBLE(H_VISIBLE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_VISIBLE(V_VISIBLE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .H_SCALE_LOG2(H_SCALE_LOG2), .V_SCALE_LOG2(V_SCALE_LOG2), .ADDR_W(ADDR_W)
  ) i_timing (
    .clk(clk), .rstN(rstN), .flipEn(ditherFlipEn),
    .fbRdEn(fbRdEn), .fbRdAddr(fbRdAddr), .stb(stb)
  );

  vqPixelPath #(
    .COLOR_BITS(COLOR_BITS), .CHANNELS(3), .PIX_W(PIX_W)
  ) i_pixel (
    .clk(clk), .rstN(rstN), .ditherEn(ditherEn), .stbIn(stb),
    .fbRdData(fbRdData), .rgbOut(rgbOut), .hSyncN(hSyncN), .vSyncN(vSyncN),
    .blankOut(blankOut), .frameStart(frameStart)
  );

endmodule

// File: rtl/vqScanOutChk.sv
module vqScanOutChk #(
  parameter int H_SYNC     = 96,
  parameter int H_TOTAL    = 800,
  parameter int V_SYNC     = 2,
  parameter int ADDR_LIMIT = 19200,
  parameter int ADDR_W     = 15,
  parameter int PIX_W      = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              fbRdEn,
  input logic [ADDR_W-1:0] fbRdAddr,
  input logic [PIX_W-1:0]  rgbOut,
  input logic              hSyncN,
  input logic              vSyncN,
  input logic              blankOut,
  input logic              frameStart
);

  logic [15:0] hLow;
  logic [31:0] vLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hLow <= '0;
      vLow <= '0;
    end else begin
      hLow <= hSyncN ? 16'd0 : hLow + 16'd1;
      vLow <= vSyncN ? 32'd0 : vLow + 32'd1;
    end
  end

  // R2: each horizontal sync pulse is H_SYNC clocks wide
  a_r2_hsync_width: assert property (@(posedge clk) disable iff (!rstN)
    (hSyncN && hLow != 16'd0) |-> (hLow == 16'(H_SYNC)));

  // R2: no visible pixel during horizontal sync
  a_r2_hsync_blank: assert property (@(posedge clk) disable iff (!rstN)
    !hSyncN |-> blankOut);

  // R3: each vertical sync pulse spans V_SYNC whole lines
  a_r3_vsync_width: assert property (@(posedge clk) disable iff (!rstN)
    (vSyncN && vLow != 32'd0) |-> (vLow == 32'(V_SYNC * H_TOTAL)));

  // R4: blanked pixels are black
  a_r4_blank_black: assert property (@(posedge clk) disable iff (!rstN)
    blankOut |-> (rgbOut == '0));

  // R5: frame pulse lasts one clock and sits on a visible pixel
  a_r5_fs_single: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  a_r5_fs_visible: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (!blankOut && hSyncN && vSyncN));

  // R6: reads stay inside the framebuffer
  a_r6_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    fbRdEn |-> (32'(fbRdAddr) < ADDR_LIMIT));

endmodule

bind vqScanOut vqScanOutChk #(
  .H_SYNC(H_SYNC),
  .H_TOTAL(H_VISIBLE + H_FRONT + H_SYNC + H_BACK),
  .V_SYNC(V_SYNC),
  .ADDR_LIMIT(SRC_CNT),
  .ADDR_W(ADDR_W),
  .PIX_W(PIX_W)
) i_vqScanOutChk (
  .clk(clk), .rstN(rstN), .fbRdEn(fbRdEn), .fbRdAddr(fbRdAddr),
  .rgbOut(rgbOut), .hSyncN(hSyncN), .vSyncN(vSyncN),
  .blankOut(blankOut), .frameStart(frameStart)
);

// File: tb/test_vqScanOut.sv
module test_vqScanOut;

  localparam int HV = 64, HF = 4, HS = 8, HB = 6;
  localparam int VV = 32, VF = 2, VS = 2, VB = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int SW = HV >> 2;
  localparam int AW = $clog2(SW * (VV >> 2));
  localparam int N_FRAMES = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ditherEn = 1'b0;
  logic          ditherFlipEn = 1'b0;
  logic          fbRdEn;
  logic [AW-1:0] fbRdAddr;
  logic [5:0]    fbRdData;
  logic [5:0]    rgbOut;
  logic          hSyncN, vSyncN, blankOut, frameStart;

  int   nChecks = 0;
  int   nErrors = 0;
  logic [5:0] seed = 6'd0;
  logic patMax = 1'b0;

  always #4 clk = ~clk;

  vqScanOut #(
    .H_VISIBLE(HV), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_VISIBLE(VV), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) i_vqScanOut (
    .clk(clk), .rstN(rstN), .ditherEn(ditherEn), .ditherFlipEn(ditherFlipEn),
    .fbRdEn(fbRdEn), .fbRdAddr(fbRdAddr), .fbRdData(fbRdData),
    .rgbOut(rgbOut), .hSyncN(hSyncN), .vSyncN(vSyncN),
    .blankOut(blankOut), .frameStart(frameStart)
  );

  function automatic logic [5:0] pat(int a);
    if (patMax) return 6'h3F;
    return 6'((a * 37 + (a >> 2)) ^ int'(seed));
  endfunction

  // Framebuffer model: one clock of read latency
  always_ff @(posedge clk) if (fbRdEn) fbRdData <= pat(int'(fbRdAddr));

  function automatic logic [5:0] shade(logic [5:0] w, logic bump);
    logic [5:0] r;
    r = w;
    if (bump) begin
      for (int c = 0; c < 3; c++) begin
        if (w[c*2 +: 2] != 2'd3) r[c*2 +: 2] = w[c*2 +: 2] + 2'd1;
      end
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int   bx = 0, by = 0, framesSeen = 0, since = 0;
  logic synced = 1'b0;
  logic expPhase = 1'b0;

  task automatic nextStimulus(int k);
    seed = 6'($urandom);
    case (k)
      1:       begin patMax = 1'b1; ditherEn = 1'b1; ditherFlipEn = 1'b0; end
      2, 3, 4: begin patMax = 1'b0; ditherEn = 1'b1; ditherFlipEn = 1'b1; end
      5:       begin patMax = 1'b0; ditherEn = 1'b1; ditherFlipEn = 1'b0; end
      default: begin patMax = 1'b0; ditherEn = 1'($urandom); ditherFlipEn = 1'($urandom); end
    endcase
  endtask

  task automatic stepCheck();
    logic [5:0] expRgb;
    logic       vis;
    if (frameStart) begin
      if (synced) check(bx == 0 && by == 0, "R5 frame period", bx + by * HT, 0);
      if (framesSeen > 0) expPhase = ditherFlipEn ? ~expPhase : 1'b0; // R9
      synced = 1'b1; bx = 0; by = 0; since = 0;
      framesSeen++;
    end
    if (!synced) return;
    vis = (bx < HV) && (by < VV);
    check(blankOut == !vis, "R4 blank", blankOut, !vis);
    check(hSyncN == !(bx >= HV + HF && bx < HV + HF + HS), "R2 hsync", hSyncN,
          !(bx >= HV + HF && bx < HV + HF + HS));
    check(vSyncN == !(by >= VV + VF && by < VV + VF + VS), "R3 vsync", vSyncN,
          !(by >= VV + VF && by < VV + VF + VS));
    check(frameStart == (bx == 0 && by == 0), "R5 pulse", frameStart, bx == 0 && by == 0);
    if (vis) begin
      // R6 address mapping, R7 pass-through, R8 dither, R9 phase
      expRgb = shade(pat((by >> 2) * SW + (bx >> 2)),
                     ditherEn && (1'(bx) ^ 1'(by) ^ expPhase));
      check(rgbOut == expRgb, ditherEn ? "R8 dither pixel" : "R7 R6 pixel",
            rgbOut, expRgb);
    end else begin
      check(rgbOut == 6'd0, "R4 black", rgbOut, 0);
    end
    if (bx == 0 && by == VV + 1) nextStimulus(framesSeen);
    bx++;
    if (bx == HT) begin bx = 0; by = (by == VT - 1) ? 0 : by + 1; end
  endtask

  initial begin
    void'($urandom(32'd5151));
    seed = 6'($urandom);
    repeat (3) begin
      @(negedge clk);
      // R1 reset state
      check(blankOut == 1'b1, "R1 blank", blankOut, 1);
      check(hSyncN && vSyncN, "R1 syncs", {hSyncN, vSyncN}, 3);
      check(rgbOut == 6'd0, "R1 rgb", rgbOut, 0);
      check(frameStart == 1'b0, "R1 frameStart", frameStart, 0);
    end
    rstN = 1'b1;
    while (framesSeen <= N_FRAMES) begin
      @(negedge clk);
      stepCheck();
      since++;
      if (since > 2 * HT * VT) begin
        check(1'b0, "watchdog", since, HT * VT);
        break;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule